// File: doc/BRIEF.md
# Page Write Commit Engine

This block sits behind the serial protocol engine of an electrically erasable memory and handles writes. The protocol engine hands it a 12-bit word address and then a stream of received data bytes. Each byte lands in a 32-entry page latch at the slot selected by the low five address bits. A per-slot valid mask records which slots really hold received data. Nothing reaches the memory array until the protocol engine reports a STOP.

On STOP, if at least one byte is latched and write protect is low, the engine starts a self-timed commit. It raises `busy` for a fixed number of system clocks. During the first page-size cycles of that window it sweeps the slots in ascending order and drives one array write for every valid slot. While `busy` is high the protocol engine withholds acknowledges, and this block ignores all of its requests. A START/abort, a STOP with write protect high, or a STOP with nothing latched drops the latch contents without any array activity.

The shared address pointer is visible so that reads can continue from where the last write stopped.

Top module: `page_commit_engine`

## Requirements
- R1: After reset `busy` and `mem_we` are low and `ptr_out` is 0.
- R2: While idle, an `addr_load` pulse sets `ptr_out` to `addr_in` and marks every latch slot empty.
- R3: While idle, a `byte_valid` pulse stores `byte_data` in the slot numbered `ptr_out[4:0]` and marks that slot valid. Only `ptr_out[4:0]` then increments, wrapping from 31 to 0, and `ptr_out[11:5]` stays the same.
- R4: If a slot receives more than one byte before STOP, only the most recent byte is committed for that slot.
- R5: The array is never written before a STOP. During the first 32 cycles of a commit, each valid slot is written exactly once, in ascending slot order. The write uses address `{ptr_out[11:5], slot}` and the slot's latched data.
- R6: A committing STOP raises `busy` in the cycle after it is sampled. `busy` then stays high for exactly WRITE_CYCLES cycles.
- R7: A STOP sampled while `wp` is high causes no array write and no `busy`, and it empties the latch.
- R8: A `start_abort` pulse while idle empties the latch, so a later STOP writes nothing.
- R9: A STOP with no valid slot causes no array write and leaves `busy` low.
- R10: While `busy` is high, `addr_load`, `byte_valid`, `stop_commit` and `start_abort` have no effect on `ptr_out`, the latch, or the commit.
- R11: After a commit, `ptr_out` holds the last written address plus one, wrapped within the page.
- R12: When several requests arrive in the same idle cycle, only one acts, in this order: `start_abort` first, then `stop_commit`, then `addr_load`, then `byte_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wp | input | 1 | Write protect; high blocks commits |
| addr_load | input | 1 | Load `addr_in` into the pointer |
| addr_in | input | 12 | Word address from the protocol engine |
| byte_valid | input | 1 | One received data byte is on `byte_data` |
| byte_data | input | 8 | Received data byte |
| stop_commit | input | 1 | STOP seen on the bus |
| start_abort | input | 1 | START or protocol abort before STOP |
| mem_we | output | 1 | Array write strobe |
| mem_addr | output | 12 | Array write address |
| mem_wdata | output | 8 | Array write data |
| busy | output | 1 | Self-timed write cycle in progress |
| ptr_out | output | 12 | Shared address pointer |

## Verification
The bench builds the block with the default 12-bit address and 32-byte page, and with WRITE_CYCLES set to 40 instead of a production-length count. That short window keeps the whole busy period within reach. Each commit can then be followed from its first sweep write to the fall of `busy`, and the cycles after the sweep, where `busy` is still high and no writes happen, are visible too. It also leaves room to drive requests into the middle of a commit. The 32-byte page lets the bench cross a page end, overrun the latch with 40 bytes, and check a full sweep in a few hundred cycles.

// File: rtl/pce_pkg.sv
package pce_pkg;
  typedef enum logic [2:0] {
    CMD_IDLE,
    CMD_ABORT,
    CMD_COMMIT,
    CMD_DROP,
    CMD_LOAD,
    CMD_BYTE
  } pce_cmd_e;
endpackage

// File: rtl/pce_page_latch.sv
module pce_page_latch #(
  parameter int PAGE_BYTES = 32,
  parameter int DATA_W     = 8,
  localparam int OFF_W     = $clog2(PAGE_BYTES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [OFF_W-1:0]  wr_idx,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              clr_mask,
  input  logic [OFF_W-1:0]  rd_idx,
  output logic [DATA_W-1:0] rd_data,
  output logic [PAGE_BYTES-1:0] mask
);
  logic [DATA_W-1:0] slot_q [PAGE_BYTES];

  for (genvar g = 0; g < PAGE_BYTES; g++) begin : g_slot
    logic hit;
    logic mask_d;
    assign hit = wr_en && (wr_idx == OFF_W'(g));

    always_comb begin
      mask_d = mask[g];
      if (clr_mask)  mask_d = 1'b0;
      else if (hit)  mask_d = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) mask[g] <= 1'b0;
      else        mask[g] <= mask_d;
    end

    always_ff @(posedge clk) begin
      if (hit) slot_q[g] <= wr_data;
    end
  end

  assign rd_data = slot_q[rd_idx];
endmodule

// File: rtl/pce_commit_timer.sv
module pce_commit_timer #(
  parameter int PAGE_BYTES   = 32,
  parameter int WRITE_CYCLES = 625000,
  localparam int OFF_W       = $clog2(PAGE_BYTES),
  localparam int TW          = $clog2(WRITE_CYCLES + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             launch,
  output logic             busy,
  output logic             done,
  output logic             scan_live,
  output logic [OFF_W-1:0] scan_idx
);
  localparam logic [TW-1:0] LAST_T = TW'(WRITE_CYCLES - 1);
  localparam logic [TW-1:0] PAGE_T = TW'(PAGE_BYTES);

  logic [TW-1:0] timer_q, timer_d;
  logic          timer_en;
  logic          busy_d;

  assign done      = busy && (timer_q == LAST_T);
  assign scan_live = busy && (timer_q < PAGE_T);
  assign scan_idx  = timer_q[OFF_W-1:0];

  always_comb begin
    busy_d   = busy;
    timer_d  = timer_q;
    timer_en = 1'b0;
    if (launch) begin
      busy_d   = 1'b1;
      timer_d  = '0;
      timer_en = 1'b1;
    end else if (busy) begin
      timer_en = 1'b1;
      if (done) begin
        busy_d  = 1'b0;
        timer_d = '0;
      end else begin
        timer_d = timer_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy    <= 1'b0;
      timer_q <= '0;
    end else begin
      busy <= busy_d;
      if (timer_en) timer_q <= timer_d;
    end
  end

  // R6
  busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !done) |=> busy);
  // R6
  timer_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (timer_q <= LAST_T));
endmodule

// File: rtl/page_commit_engine.sv
module page_commit_engine #(
  parameter int ADDR_W       = 12,
  parameter int DATA_W       = 8,
  parameter int PAGE_BYTES   = 32,
  parameter int WRITE_CYCLES = 625000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wp,
  input  logic              addr_load,
  input  logic [ADDR_W-1:0] addr_in,
  input  logic              byte_valid,
  input  logic [DATA_W-1:0] byte_data,
  input  logic              stop_commit,
  input  logic              start_abort,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  output logic              busy,
  output logic [ADDR_W-1:0] ptr_out
);
  import pce_pkg::*;

  localparam int OFF_W = $clog2(PAGE_BYTES);

  pce_cmd_e          cmd;
  logic [ADDR_W-1:0] ptr_q, ptr_d;
  logic              ptr_en;
  logic [PAGE_BYTES-1:0] mask;
  logic              done, scan_live;
  logic [OFF_W-1:0]  scan_idx;
  logic [DATA_W-1:0] scan_data;
  logic [OFF_W-1:0]  ptr_off_inc;

  // request arbitration, abort > stop > load > byte
  always_comb begin
    cmd = CMD_IDLE;
    if (!busy) begin
      if (start_abort)      cmd = CMD_ABORT;
      else if (stop_commit) cmd = (|mask && !wp) ? CMD_COMMIT : CMD_DROP;
      else if (addr_load)   cmd = CMD_LOAD;
      else if (byte_valid)  cmd = CMD_BYTE;
    end
  end

  assign ptr_off_inc = ptr_q[OFF_W-1:0] + 1'b1;

  always_comb begin
    ptr_d  = ptr_q;
    ptr_en = 1'b0;
    if (cmd == CMD_LOAD) begin
      ptr_d  = addr_in;
      ptr_en = 1'b1;
    end else if (cmd == CMD_BYTE) begin
      ptr_d  = {ptr_q[ADDR_W-1:OFF_W], ptr_off_inc};
      ptr_en = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      ptr_q <= '0;
    else if (ptr_en) ptr_q <= ptr_d;
  end

  pce_page_latch #(.PAGE_BYTES(PAGE_BYTES), .DATA_W(DATA_W)) i_latch (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (cmd == CMD_BYTE),
    .wr_idx   (ptr_q[OFF_W-1:0]),
    .wr_data  (byte_data),
    .clr_mask (cmd == CMD_ABORT || cmd == CMD_DROP || cmd == CMD_LOAD || done),
    .rd_idx   (scan_idx),
    .rd_data  (scan_data),
    .mask     (mask)
  );

  pce_commit_timer #(.PAGE_BYTES(PAGE_BYTES), .WRITE_CYCLES(WRITE_CYCLES)) i_timer (
    .clk       (clk),
    .rst_n     (rst_n),
    .launch    (cmd == CMD_COMMIT),
    .busy      (busy),
    .done      (done),
    .scan_live (scan_live),
    .scan_idx  (scan_idx)
  );

  assign mem_we    = scan_live && mask[scan_idx];
  assign mem_addr  = {ptr_q[ADDR_W-1:OFF_W], scan_idx};
  assign mem_wdata = scan_data;
  assign ptr_out   = ptr_q;

  // R10
  ptr_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(ptr_out));
  // R7
  wp_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> !$past(wp));
  // R9
  start_from_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> ($past(stop_commit) && !$past(start_abort)));
  // R5
  same_page_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> (busy && mem_addr[ADDR_W-1:OFF_W] == ptr_out[ADDR_W-1:OFF_W]));
endmodule

// File: tb/test_page_commit_engine.sv
module test_page_commit_engine;
  localparam int AW = 12;
  localparam int PG = 32;
  localparam int WC = 40;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wp = 1'b0, addr_load = 1'b0, byte_valid = 1'b0, stop_commit = 1'b0, start_abort = 1'b0;
  logic [AW-1:0] addr_in = '0;
  logic [7:0] byte_data = '0;
  logic mem_we, busy;
  logic [AW-1:0] mem_addr, ptr_out;
  logic [7:0] mem_wdata;

  always #4 clk = ~clk;

  page_commit_engine #(.ADDR_W(AW), .DATA_W(8), .PAGE_BYTES(PG), .WRITE_CYCLES(WC)) i_page_commit_engine (
    .clk(clk), .rst_n(rst_n), .wp(wp), .addr_load(addr_load), .addr_in(addr_in),
    .byte_valid(byte_valid), .byte_data(byte_data), .stop_commit(stop_commit),
    .start_abort(start_abort), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .busy(busy), .ptr_out(ptr_out)
  );

  int checks = 0;
  int errors = 0;
  bit percycle_on = 1'b0;

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  // behavioural reference model
  int m_ptr = 0;
  int m_busy = 0;
  bit m_mask [PG];
  logic [7:0] m_data [PG];
  logic [7:0] m_mem [4096];
  logic [7:0] d_mem [4096];
  int wr_count = 0;

  initial begin
    for (int i = 0; i < 4096; i++) begin m_mem[i] = '0; d_mem[i] = '0; end
    for (int i = 0; i < PG; i++) begin m_mask[i] = 1'b0; m_data[i] = '0; end
  end

  function automatic bit any_mask();
    for (int i = 0; i < PG; i++) if (m_mask[i]) return 1'b1;
    return 1'b0;
  endfunction

  task automatic clear_mask();
    for (int i = 0; i < PG; i++) m_mask[i] = 1'b0;
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      m_ptr = 0; m_busy = 0; clear_mask();
    end else if (m_busy > 0) begin
      int el;
      el = WC - m_busy;
      if (el < PG && m_mask[el]) m_mem[(m_ptr / PG) * PG + el] = m_data[el];
      m_busy--;
      if (m_busy == 0) clear_mask();
    end else if (start_abort) begin
      clear_mask();
    end else if (stop_commit) begin
      if (any_mask() && !wp) m_busy = WC;
      else clear_mask();
    end else if (addr_load) begin
      m_ptr = int'(addr_in); clear_mask();
    end else if (byte_valid) begin
      m_data[m_ptr % PG] = byte_data;
      m_mask[m_ptr % PG] = 1'b1;
      m_ptr = (m_ptr / PG) * PG + ((m_ptr + 1) % PG);
    end
  end

  always @(posedge clk) begin
    if (rst_n && mem_we) begin
      d_mem[mem_addr] = mem_wdata;
      wr_count++;
    end
  end

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (percycle_on) begin
      int el;
      bit exp_we;
      el = WC - m_busy;
      exp_we = (m_busy > 0) && (el < PG) && m_mask[el % PG];
      check("R6 busy", int'(busy), int'(m_busy > 0));
      check("R5 mem_we", int'(mem_we), int'(exp_we));
      check("R11 ptr_out", int'(ptr_out), m_ptr);
      if (exp_we) begin
        check("R5 mem_addr", int'(mem_addr), (m_ptr / PG) * PG + el);
        check("R5 mem_wdata", int'(mem_wdata), int'(m_data[el]));
      end
    end
  end

  task automatic drive(input logic ld, input logic [AW-1:0] a, input logic bv,
                       input logic [7:0] d, input logic st, input logic ab);
    addr_load = ld; addr_in = a; byte_valid = bv; byte_data = d;
    stop_commit = st; start_abort = ab;
    @(negedge clk);
    addr_load = 1'b0; byte_valid = 1'b0; stop_commit = 1'b0; start_abort = 1'b0;
  endtask

  task automatic wait_idle();
    while (busy) @(negedge clk);
    @(negedge clk);
  endtask

  initial begin
    int base;
    int cnt;
    int mism;
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 busy", int'(busy), 0);
    check("R1 mem_we", int'(mem_we), 0);
    check("R1 ptr_out", int'(ptr_out), 0);
    rst_n = 1'b1;
    @(negedge clk);
    percycle_on = 1'b1;

    // R2 / R6 single byte write
    drive(1, 12'h123, 0, 0, 0, 0);
    check("R2 ptr after load", int'(ptr_out), 'h123);
    base = wr_count;
    drive(0, 0, 1, 8'hA5, 0, 0);
    check("R5 no write before stop", wr_count - base, 0);
    drive(0, 0, 0, 0, 1, 0);
    cnt = 0;
    while (busy) begin cnt++; @(negedge clk); end
    check("R6 busy length", cnt, WC);
    check("R5 single write count", wr_count - base, 1);
    check("R5 single write data", int'(d_mem['h123]), 'hA5);

    // R3 / R11 page wrap
    drive(1, 12'h3FC, 0, 0, 0, 0);
    base = wr_count;
    drive(0, 0, 1, 8'h11, 0, 0);
    drive(0, 0, 1, 8'h22, 0, 0);
    drive(0, 0, 1, 8'h33, 0, 0);
    drive(0, 0, 1, 8'h44, 0, 0);
    drive(0, 0, 1, 8'h55, 0, 0);
    check("R3 ptr wraps in page", int'(ptr_out), 'h3E1);
    drive(0, 0, 0, 0, 1, 0);
    wait_idle();
    check("R3 wrap count", wr_count - base, 5);
    check("R3 wrapped byte", int'(d_mem['h3E0]), 'h55);
    check("R3 next page untouched", int'(d_mem['h400]), 0);
    check("R3 last in page", int'(d_mem['h3FF]), 'h44);
    check("R11 ptr after commit", int'(ptr_out), 'h3E1);

    // R4 overrun of the latch
    drive(1, 12'h040, 0, 0, 0, 0);
    base = wr_count;
    for (int i = 1; i <= 40; i++) drive(0, 0, 1, 8'(i), 0, 0);
    drive(0, 0, 0, 0, 1, 0);
    wait_idle();
    check("R4 overrun count", wr_count - base, 32);
    check("R4 overwritten slot", int'(d_mem['h040]), 33);
    check("R4 kept slot", int'(d_mem['h048]), 9);
    check("R11 ptr after overrun", int'(ptr_out), 'h048);

    // R7 write protect
    drive(1, 12'h200, 0, 0, 0, 0);
    base = wr_count;
    drive(0, 0, 1, 8'h77, 0, 0);
    wp = 1'b1;
    drive(0, 0, 0, 0, 1, 0);
    check("R7 no busy under wp", int'(busy), 0);
    wp = 1'b0;
    drive(0, 0, 0, 0, 1, 0);
    check("R7 latch discarded", int'(busy), 0);
    check("R7 no writes", wr_count - base, 0);
    check("R7 array unchanged", int'(d_mem['h200]), 0);

    // R8 abort
    drive(1, 12'h300, 0, 0, 0, 0);
    base = wr_count;
    drive(0, 0, 1, 8'h66, 0, 0);
    drive(0, 0, 0, 0, 0, 1);
    drive(0, 0, 0, 0, 1, 0);
    check("R8 no busy after abort", int'(busy), 0);
    check("R8 no writes", wr_count - base, 0);

    // R9 address-only stop
    drive(1, 12'h500, 0, 0, 0, 0);
    base = wr_count;
    drive(0, 0, 0, 0, 1, 0);
    check("R9 no busy", int'(busy), 0);
    check("R9 no writes", wr_count - base, 0);
    check("R9 ptr kept", int'(ptr_out), 'h500);

    // R10 requests during busy
    drive(1, 12'h600, 0, 0, 0, 0);
    base = wr_count;
    drive(0, 0, 1, 8'h10, 0, 0);
    drive(0, 0, 0, 0, 1, 0);
    drive(1, 12'h700, 0, 0, 0, 0);
    drive(0, 0, 1, 8'h99, 0, 0);
    drive(0, 0, 0, 0, 0, 1);
    drive(0, 0, 0, 0, 1, 0);
    check("R10 ptr frozen", int'(ptr_out), 'h601);
    check("R10 still busy", int'(busy), 1);
    wait_idle();
    check("R10 write count", wr_count - base, 1);
    check("R10 data", int'(d_mem['h600]), 'h10);
    check("R10 ignored byte", int'(d_mem['h700]), 0);
    check("R10 ptr after", int'(ptr_out), 'h601);

    // R12 same-cycle arbitration
    drive(1, 12'h680, 0, 0, 0, 0);
    base = wr_count;
    drive(0, 0, 1, 8'h21, 0, 0);
    drive(0, 0, 1, 8'h5A, 0, 1);
    check("R12 abort beats byte", int'(ptr_out), 'h681);
    drive(0, 0, 0, 0, 1, 0);
    check("R12 nothing left", int'(busy), 0);
    drive(1, 12'h6A0, 0, 0, 0, 0);
    drive(0, 0, 1, 8'h42, 0, 0);
    drive(1, 12'h6C0, 0, 0, 1, 0);
    check("R12 stop beats load", int'(busy), 1);
    check("R12 ptr kept", int'(ptr_out), 'h6A1);
    wait_idle();
    check("R12 write count", wr_count - base, 1);
    check("R12 data", int'(d_mem['h6A0]), 'h42);

    percycle_on = 1'b0;
    mism = 0;
    for (int i = 0; i < 4096; i++) if (d_mem[i] !== m_mem[i]) mism++;
    check("R5 array matches model", mism, 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(8 * 200000);
    checks++;
    errors++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule